// File: doc/BRIEF.md
# Checksummed Command/Reply Exchange Sequencer

This block runs one complete command/reply exchange with a slave node. It sits on top of a byte-level two-wire bus master. A host loads a 7-bit slave address, five command bytes and a return-address byte. The sequencer then writes a command frame that ends in an 8-bit rolling-sum checksum. Next it reads back a single acknowledgement byte. When that byte announces a reply, the sequencer reads a length-prefixed reply frame, checks the reply's checksum and, if the checksum is good, writes a final acknowledgement.

The byte master below is driven through a request/done handshake. Each request names one operation: an address word (start condition plus address and direction bit), a byte write, a byte read, or a stop. Bit timing, start/stop generation and arbitration all belong to that lower layer. Towards the host the block provides a busy level, a one-cycle done pulse and a set of outcome flags. These flags are: reply delivered, negative acknowledgement, acknowledgement timeout, framing error and checksum error. The reply data bytes leave the block as a valid-qualified byte stream.

Top module: `cmdrsp_seq`

## Requirements
- R1: A load issues, in order: an address op with byte {slave,0}, five write ops carrying command bytes 0..4 (byte 0 = `cmd_payload[7:0]`), a write op with the return address, a write op with the checksum, then a stop op. bm_op codes are 0 = address word, 1 = write, 2 = read, 3 = stop. A request holds its op and data until done.
- R2: The command checksum is the sum, modulo 256, of the five command bytes and the return-address byte.
- R3: After the command stop, the block issues an address op {slave,1}, then one read op for the acknowledgement byte, then a stop op.
- R4: Acknowledgement 0x00 ends the exchange with every outcome flag clear, and no further bus ops are issued.
- R5: Acknowledgement 0x01 starts a reply read: an address op {slave,1}, a read op for the length byte, one read op per data byte, a read op for the checksum, then a stop op. Each data byte appears once, in order, on rx_data with rx_valid, one cycle after its done. A length of 0 goes straight to the checksum read.
- R6: If the reply checksum equals the modulo-256 sum of the length byte and the data bytes, the block issues an address op {slave,0}, a write op of 0x00 and a stop op, then sets flag_reply.
- R7: A reply checksum mismatch sets flag_csum, and no final acknowledgement ops are issued after the reply stop.
- R8: A length byte of 126 or more sets flag_framing. The block then issues a stop op right after the length read, reads no data and emits no rx_valid. A length of 125 is accepted.
- R9: Any acknowledgement other than 0x00 or 0x01 sets flag_nak, and no reply read follows.
- R10: If the acknowledgement read request has not completed `ack_limit` cycles after it was raised, the request is withdrawn, flag_timeout is set and the block goes idle. A done that arrives in exactly cycle `ack_limit` is accepted.
- R11: busy rises in the cycle after cmd_valid is accepted while idle, and stays high until the exchange ends. A cmd_valid that arrives while busy has no effect on the bus ops issued.
- R12: done pulses for one cycle, in the first cycle busy is low. The outcome flags hold, with at most one of them set, until the next accepted load.
- R13: While reset is applied and right after it, busy, done, bm_req and all outcome flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Load strobe for a new exchange |
| cmd_slave | input | 7 | Slave address |
| cmd_payload | input | 40 | Five command bytes, byte 0 in bits 7:0 |
| cmd_ret | input | 8 | Return-address byte |
| ack_limit | input | 16 | Acknowledgement wait limit in cycles |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| flag_reply | output | 1 | Reply received intact and acknowledged |
| flag_nak | output | 1 | Unrecognised acknowledgement byte |
| flag_timeout | output | 1 | Acknowledgement byte not delivered in time |
| flag_framing | output | 1 | Reply length out of range |
| flag_csum | output | 1 | Reply checksum mismatch |
| rx_valid | output | 1 | Reply data byte strobe |
| rx_data | output | 8 | Reply data byte |
| bm_req | output | 1 | Operation request to the byte master |
| bm_op | output | 2 | Operation code |
| bm_wdata | output | 8 | Address word or write byte |
| bm_done | input | 1 | Operation completed (one cycle) |
| bm_rdata | input | 8 | Byte returned by a read op |

## Verification
Two events can land in the same cycle: the acknowledgement byte's done and the expiry of the acknowledgement wait counter. The bench's byte-master model holds that read for a chosen number of cycles after the request appears. It sets that delay equal to `ack_limit`, and then to one more than it. The first case must produce a normal exchange and the second a timeout with the request withdrawn. A second overlap is a host load that arrives mid-exchange. The bench compares the full logged op sequence against the one computed from the original command, to show the stray load left no trace.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

    localparam int PAYLOAD_BYTES   = 5;
    localparam int REPLY_LEN_LIMIT = 126;

    localparam logic [7:0] ACK_NO_REPLY = 8'h00;
    localparam logic [7:0] ACK_REPLY    = 8'h01;
    localparam logic [7:0] FINAL_ACK    = 8'h00;

    typedef enum logic [1:0] {
        OP_ADDR = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2,
        OP_STOP = 2'd3
    } bm_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_C_ADDR, ST_C_BYTE, ST_C_STOP,
        ST_A_ADDR, ST_A_READ, ST_A_STOP,
        ST_R_ADDR, ST_R_LEN, ST_R_DATA, ST_R_SUM, ST_R_STOP,
        ST_F_ADDR, ST_F_BYTE, ST_F_STOP
    } seq_state_e;

    typedef enum logic [1:0] {
        ACK_K_DONE,
        ACK_K_MORE,
        ACK_K_BAD
    } ack_kind_e;

    typedef struct packed {
        logic reply;
        logic nak;
        logic tmo;
        logic frame;
        logic csum;
    } seq_flags_t;

    typedef struct packed {
        bm_op_e     op;
        logic [7:0] data;
    } bm_word_t;

    function automatic ack_kind_e classify_ack(input logic [7:0] b);
        if (b == ACK_NO_REPLY)   return ACK_K_DONE;
        else if (b == ACK_REPLY) return ACK_K_MORE;
        else                     return ACK_K_BAD;
    endfunction

    function automatic logic [7:0] addr_word(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

endpackage

// File: rtl/cmdrsp_sum8.sv
module cmdrsp_sum8 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum
);
    logic [W-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum_q <= '0;
        else if (add)
            sum_q <= sum_q + din;
    end

    assign sum = sum_q;
endmodule

// File: rtl/cmdrsp_wait.sv
module cmdrsp_wait #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != limit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/cmdrsp_seq.sv
module cmdrsp_seq
    import cmdrsp_pkg::*;
#(
    parameter int PAYLOAD_N = PAYLOAD_BYTES,
    parameter int TMO_W     = 16,
    parameter int LEN_LIMIT = REPLY_LEN_LIMIT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [6:0]             cmd_slave,
    input  logic [PAYLOAD_N*8-1:0] cmd_payload,
    input  logic [7:0]             cmd_ret,
    input  logic [TMO_W-1:0]       ack_limit,
    output logic                   busy,
    output logic                   done,
    output logic                   flag_reply,
    output logic                   flag_nak,
    output logic                   flag_timeout,
    output logic                   flag_framing,
    output logic                   flag_csum,
    output logic                   rx_valid,
    output logic [7:0]             rx_data,
    output logic                   bm_req,
    output logic [1:0]             bm_op,
    output logic [7:0]             bm_wdata,
    input  logic                   bm_done,
    input  logic [7:0]             bm_rdata
);
    localparam int IDX_W    = 8;
    localparam int CMD_LAST = PAYLOAD_N + 1;

    seq_state_e             st_q, st_d;
    logic [IDX_W-1:0]       idx_q, idx_d, idx_nx;
    logic [6:0]             slave_q;
    logic [PAYLOAD_N*8-1:0] pl_q;
    logic [7:0]             ret_q, ack_q;
    logic [IDX_W-1:0]       len_q;
    logic                   pend_frame_q, pend_csum_q;
    seq_flags_t             flags_q, fin_flags;
    logic                   done_q, rxv_q;
    logic [7:0]             rxd_q;

    logic       load, fin_en, ack_ld, len_ld, rx_ld;
    logic       pend_frame_set, pend_csum_set;
    logic       acc_clr, acc_add, tmo_hit;
    logic [7:0] acc_din, acc_sum, cmd_byte;
    bm_word_t   word;

    assign load   = (st_q == ST_IDLE) && cmd_valid;
    assign idx_nx = idx_q + 1'b1;

    cmdrsp_sum8 #(.W(8)) u_sum (
        .clk (clk),
        .rst (rst),
        .clr (acc_clr),
        .add (acc_add),
        .din (acc_din),
        .sum (acc_sum)
    );

    cmdrsp_wait #(.TW(TMO_W)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .run     (st_q == ST_A_READ),
        .limit   (ack_limit),
        .expired (tmo_hit)
    );

    // Byte placed on the bus during the command frame
    always_comb begin
        cmd_byte = acc_sum;
        if (idx_q == IDX_W'(PAYLOAD_N))
            cmd_byte = ret_q;
        for (int i = 0; i < PAYLOAD_N; i++)
            if (idx_q == IDX_W'(i))
                cmd_byte = pl_q[i*8 +: 8];
    end

    always_comb begin
        st_d           = st_q;
        idx_d          = idx_q;
        word           = '{op: OP_STOP, data: 8'h00};
        acc_clr        = 1'b0;
        acc_add        = 1'b0;
        acc_din        = bm_rdata;
        fin_en         = 1'b0;
        fin_flags      = '0;
        ack_ld         = 1'b0;
        len_ld         = 1'b0;
        rx_ld          = 1'b0;
        pend_frame_set = 1'b0;
        pend_csum_set  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    st_d    = ST_C_ADDR;
                    idx_d   = '0;
                    acc_clr = 1'b1;
                end
            end
            ST_C_ADDR: begin
                word = '{op: OP_ADDR, data: addr_word(slave_q, 1'b0)};
                if (bm_done) st_d = ST_C_BYTE;
            end
            ST_C_BYTE: begin
                word = '{op: OP_WR, data: cmd_byte};
                if (bm_done) begin
                    if (idx_q == IDX_W'(CMD_LAST)) begin
                        st_d = ST_C_STOP;
                    end else begin
                        idx_d   = idx_nx;
                        acc_add = 1'b1;
                        acc_din = cmd_byte;
                    end
                end
            end
            ST_C_STOP: begin
                if (bm_done) st_d = ST_A_ADDR;
            end
            ST_A_ADDR: begin
                word = '{op: OP_ADDR, data: addr_word(slave_q, 1'b1)};
                if (bm_done) st_d = ST_A_READ;
            end
            ST_A_READ: begin
                word = '{op: OP_RD, data: 8'h00};
                if (bm_done) begin
                    ack_ld = 1'b1;
                    st_d   = ST_A_STOP;
                end else if (tmo_hit) begin
                    fin_en        = 1'b1;
                    fin_flags.tmo = 1'b1;
                    st_d          = ST_IDLE;
                end
            end
            ST_A_STOP: begin
                if (bm_done) begin
                    case (classify_ack(ack_q))
                        ACK_K_DONE: begin
                            fin_en = 1'b1;
                            st_d   = ST_IDLE;
                        end
                        ACK_K_MORE: st_d = ST_R_ADDR;
                        default: begin
                            fin_en        = 1'b1;
                            fin_flags.nak = 1'b1;
                            st_d          = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_R_ADDR: begin
                word = '{op: OP_ADDR, data: addr_word(slave_q, 1'b1)};
                if (bm_done) begin
                    acc_clr = 1'b1;
                    st_d    = ST_R_LEN;
                end
            end
            ST_R_LEN: begin
                word = '{op: OP_RD, data: 8'h00};
                if (bm_done) begin
                    len_ld  = 1'b1;
                    acc_add = 1'b1;
                    idx_d   = '0;
                    if (bm_rdata >= 8'(LEN_LIMIT)) begin
                        pend_frame_set = 1'b1;
                        st_d           = ST_R_STOP;
                    end else if (bm_rdata == 8'h00) begin
                        st_d = ST_R_SUM;
                    end else begin
                        st_d = ST_R_DATA;
                    end
                end
            end
            ST_R_DATA: begin
                word = '{op: OP_RD, data: 8'h00};
                if (bm_done) begin
                    acc_add = 1'b1;
                    rx_ld   = 1'b1;
                    idx_d   = idx_nx;
                    if (idx_nx == len_q) st_d = ST_R_SUM;
                end
            end
            ST_R_SUM: begin
                word = '{op: OP_RD, data: 8'h00};
                if (bm_done) begin
                    pend_csum_set = (bm_rdata != acc_sum);
                    st_d          = ST_R_STOP;
                end
            end
            ST_R_STOP: begin
                if (bm_done) begin
                    if (pend_frame_q) begin
                        fin_en          = 1'b1;
                        fin_flags.frame = 1'b1;
                        st_d            = ST_IDLE;
                    end else if (pend_csum_q) begin
                        fin_en         = 1'b1;
                        fin_flags.csum = 1'b1;
                        st_d           = ST_IDLE;
                    end else begin
                        st_d = ST_F_ADDR;
                    end
                end
            end
            ST_F_ADDR: begin
                word = '{op: OP_ADDR, data: addr_word(slave_q, 1'b0)};
                if (bm_done) st_d = ST_F_BYTE;
            end
            ST_F_BYTE: begin
                word = '{op: OP_WR, data: FINAL_ACK};
                if (bm_done) st_d = ST_F_STOP;
            end
            ST_F_STOP: begin
                if (bm_done) begin
                    fin_en          = 1'b1;
                    fin_flags.reply = 1'b1;
                    st_d            = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            idx_q        <= '0;
            slave_q      <= '0;
            pl_q         <= '0;
            ret_q        <= '0;
            ack_q        <= '0;
            len_q        <= '0;
            pend_frame_q <= 1'b0;
            pend_csum_q  <= 1'b0;
            flags_q      <= '0;
            done_q       <= 1'b0;
            rxv_q        <= 1'b0;
            rxd_q        <= '0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            done_q <= fin_en;
            rxv_q  <= rx_ld;
            if (rx_ld)  rxd_q <= bm_rdata;
            if (ack_ld) ack_q <= bm_rdata;
            if (len_ld) len_q <= bm_rdata;
            if (pend_frame_set) pend_frame_q <= 1'b1;
            if (pend_csum_set)  pend_csum_q  <= 1'b1;
            if (load) begin
                slave_q      <= cmd_slave;
                pl_q         <= cmd_payload;
                ret_q        <= cmd_ret;
                flags_q      <= '0;
                pend_frame_q <= 1'b0;
                pend_csum_q  <= 1'b0;
            end
            if (fin_en) flags_q <= fin_flags;
        end
    end

    assign busy         = (st_q != ST_IDLE);
    assign done         = done_q;
    assign flag_reply   = flags_q.reply;
    assign flag_nak     = flags_q.nak;
    assign flag_timeout = flags_q.tmo;
    assign flag_framing = flags_q.frame;
    assign flag_csum    = flags_q.csum;
    assign rx_valid     = rxv_q;
    assign rx_data      = rxd_q;
    assign bm_req       = (st_q != ST_IDLE);
    assign bm_op        = word.op;
    assign bm_wdata     = word.data;
endmodule

// File: rtl/cmdrsp_chk.sv
module cmdrsp_chk
    import cmdrsp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       busy,
    input logic       done,
    input logic [4:0] flags,
    input logic       rx_valid,
    input logic       bm_req,
    input logic [1:0] bm_op,
    input logic [7:0] bm_wdata,
    input logic       bm_done
);
    // R1: a pending non-read request keeps its op and data until done
    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (bm_req && !bm_done && bm_op != OP_RD) |=> (bm_req && $stable(bm_op) && $stable(bm_wdata)));

    // R11: an accepted load opens with a write-direction address word
    p_load_start_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid) |=> (busy && bm_req && bm_op == OP_ADDR && bm_wdata[0] == 1'b0));

    // R12: end of exchange is marked by done
    p_done_on_fall_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_one_outcome_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags));

    p_flags_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cmd_valid) |=> $stable(flags));

    // R5: reply data only streams during an exchange
    p_rx_in_exchange_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (busy && !done));

    // R10: a timeout is reported together with the end of exchange
    p_tmo_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> done);
endmodule

bind cmdrsp_seq cmdrsp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .flags     ({flag_reply, flag_nak, flag_timeout, flag_framing, flag_csum}),
    .rx_valid  (rx_valid),
    .bm_req    (bm_req),
    .bm_op     (bm_op),
    .bm_wdata  (bm_wdata),
    .bm_done   (bm_done)
);

// File: tb/test_cmdrsp_seq.sv
module test_cmdrsp_seq;
    import cmdrsp_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [6:0]  cmd_slave;
    logic [39:0] cmd_payload;
    logic [7:0]  cmd_ret;
    logic [15:0] ack_limit;
    logic        busy, done;
    logic        flag_reply, flag_nak, flag_timeout, flag_framing, flag_csum;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        bm_req;
    logic [1:0]  bm_op;
    logic [7:0]  bm_wdata;
    logic        bm_done;
    logic [7:0]  bm_rdata;

    always #10 clk = ~clk;

    cmdrsp_seq i_cmdrsp_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_slave(cmd_slave),
        .cmd_payload(cmd_payload), .cmd_ret(cmd_ret), .ack_limit(ack_limit),
        .busy(busy), .done(done), .flag_reply(flag_reply), .flag_nak(flag_nak),
        .flag_timeout(flag_timeout), .flag_framing(flag_framing), .flag_csum(flag_csum),
        .rx_valid(rx_valid), .rx_data(rx_data), .bm_req(bm_req), .bm_op(bm_op),
        .bm_wdata(bm_wdata), .bm_done(bm_done), .bm_rdata(bm_rdata)
    );

    int checks = 0;
    int fails  = 0;

    // byte-master model state
    logic [9:0] wlog [0:511];
    int         wn;
    logic [7:0] rq [0:255];
    int         rp;
    int         gen_lat, ack_lat;
    bit         ack_hang;

    logic [7:0] rxlog [0:255];
    int         rxn;

    localparam logic [4:0] F_NONE  = 5'b00000;
    localparam logic [4:0] F_REPLY = 5'b10000;
    localparam logic [4:0] F_NAK   = 5'b01000;
    localparam logic [4:0] F_TMO   = 5'b00100;
    localparam logic [4:0] F_FRAME = 5'b00010;
    localparam logic [4:0] F_CSUM  = 5'b00001;

    function automatic logic [4:0] cur_flags();
        return {flag_reply, flag_nak, flag_timeout, flag_framing, flag_csum};
    endfunction

    function automatic string flag_tag(input logic [4:0] f);
        case (f)
            F_REPLY: return "R6";
            F_NAK:   return "R9";
            F_TMO:   return "R10";
            F_FRAME: return "R8";
            F_CSUM:  return "R7";
            default: return "R4";
        endcase
    endfunction

    function automatic string log_tag(input int i, input int en, input logic [4:0] f);
        if (i == 7)  return "R2";
        if (i < 9)   return "R1";
        if (i < 12)  return "R3";
        if (f == F_REPLY && i >= en - 3) return "R6";
        return "R5";
    endfunction

    function automatic logic [9:0] w(input logic [1:0] op, input logic [7:0] d);
        return {op, d};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // byte-master responder
    initial begin
        logic [1:0] op;
        logic [7:0] wd;
        int         lat;
        bit         ab;
        bm_done  = 1'b0;
        bm_rdata = 8'h00;
        forever begin
            @(negedge clk);
            bm_done = 1'b0;
            if (!rst && bm_req) begin
                op = bm_op;
                wd = bm_wdata;
                if (wn < 512)
                    wlog[wn] = {op, (op == OP_RD || op == OP_STOP) ? 8'h00 : wd};
                wn++;
                lat = (op == OP_RD && rp == 0) ? ack_lat : gen_lat;
                ab  = 1'b0;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!bm_req) begin
                        ab = 1'b1;
                        break;
                    end
                end
                if (!ab && op == OP_RD && rp == 0 && ack_hang) begin
                    while (bm_req) @(negedge clk);
                    ab = 1'b1;
                end
                if (!ab && !bm_req) ab = 1'b1;
                if (!ab) begin
                    bm_done = 1'b1;
                    if (op == OP_RD) begin
                        bm_rdata = rq[rp];
                        rp++;
                    end else begin
                        bm_rdata = 8'h00;
                    end
                end
            end
        end
    end

    // reply stream collector
    initial begin
        rxn = 0;
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                if (rxn < 256) rxlog[rxn] = rx_data;
                rxn++;
            end
        end
    end

    task automatic run_xfer(input logic [6:0] sl, input logic [39:0] pl, input logic [7:0] ret,
                            input logic [7:0] ack, input int len, input bit bad_sum,
                            input bit hang, input int alat, input logic [15:0] lim,
                            input bit poke);
        logic [9:0] exp [0:511];
        logic [7:0] data [0:255];
        logic [7:0] cs, csc;
        logic [4:0] ef;
        int         en, guard, bad_i, exp_rx;
        bit         to, seen, logok;
        for (int i = 0; i < 256; i++) data[i] = 8'($urandom());
        rq[0] = ack;
        rq[1] = 8'(len);
        cs = 8'(len);
        if (len < 126) begin
            for (int i = 0; i < len; i++) begin
                rq[2 + i] = data[i];
                cs = cs + data[i];
            end
            rq[2 + len] = bad_sum ? (cs ^ 8'h5A) : cs;
        end
        rp = 0; wn = 0; rxn = 0;
        ack_lat = alat; ack_hang = hang; ack_limit = lim;

        en = 0;
        exp[en++] = w(OP_ADDR, {sl, 1'b0});
        csc = ret;
        for (int b = 0; b < 5; b++) begin
            exp[en++] = w(OP_WR, pl[b*8 +: 8]);
            csc = csc + pl[b*8 +: 8];
        end
        exp[en++] = w(OP_WR, ret);
        exp[en++] = w(OP_WR, csc);
        exp[en++] = w(OP_STOP, 8'h00);
        exp[en++] = w(OP_ADDR, {sl, 1'b1});
        exp[en++] = w(OP_RD, 8'h00);
        to = hang || (alat > int'(lim));
        exp_rx = 0;
        if (to) begin
            ef = F_TMO;
        end else begin
            exp[en++] = w(OP_STOP, 8'h00);
            if (ack == 8'h00) begin
                ef = F_NONE;
            end else if (ack == 8'h01) begin
                exp[en++] = w(OP_ADDR, {sl, 1'b1});
                exp[en++] = w(OP_RD, 8'h00);
                if (len >= 126) begin
                    exp[en++] = w(OP_STOP, 8'h00);
                    ef = F_FRAME;
                end else begin
                    for (int i = 0; i < len; i++) exp[en++] = w(OP_RD, 8'h00);
                    exp[en++] = w(OP_RD, 8'h00);
                    exp[en++] = w(OP_STOP, 8'h00);
                    exp_rx = len;
                    if (bad_sum) begin
                        ef = F_CSUM;
                    end else begin
                        exp[en++] = w(OP_ADDR, {sl, 1'b0});
                        exp[en++] = w(OP_WR, 8'h00);
                        exp[en++] = w(OP_STOP, 8'h00);
                        ef = F_REPLY;
                    end
                end
            end else begin
                ef = F_NAK;
            end
        end

        @(negedge clk);
        cmd_slave = sl; cmd_payload = pl; cmd_ret = ret; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after load", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R11", "busy before stray load", int'(busy), 1);
            cmd_slave = sl ^ 7'h01; cmd_payload = ~pl; cmd_ret = ~ret; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end

        guard = 0; seen = 1'b0;
        while (guard < 5000) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
            guard++;
        end
        chk(seen, "R12", "done pulse seen", int'(seen), 1);
        chk(busy == 1'b0, "R12", "busy low with done", int'(busy), 0);
        chk(cur_flags() == ef, flag_tag(ef), "outcome flags", int'(cur_flags()), int'(ef));
        repeat (3) @(negedge clk);

        chk(wn == en, log_tag(wn < en ? wn : en, en, ef), "bus op count", wn, en);
        bad_i = -1;
        for (int i = 0; i < en && i < wn; i++)
            if (bad_i < 0 && wlog[i] !== exp[i]) bad_i = i;
        logok = (bad_i < 0) && (wn == en);
        if (bad_i >= 0)
            chk(1'b0, log_tag(bad_i, en, ef), "bus op word", int'(wlog[bad_i]), int'(exp[bad_i]));
        else
            chk(1'b1, "R1", "bus op words", 0, 0);
        if (poke)
            chk(logok, "R11", "stray load left bus ops unchanged", int'(logok), 1);

        chk(rxn == exp_rx, (ef == F_FRAME) ? "R8" : "R5", "reply byte count", rxn, exp_rx);
        bad_i = -1;
        for (int i = 0; i < exp_rx && i < rxn; i++)
            if (bad_i < 0 && rxlog[i] !== data[i]) bad_i = i;
        if (bad_i >= 0)
            chk(1'b0, "R5", "reply byte value", int'(rxlog[bad_i]), int'(data[bad_i]));
        chk(cur_flags() == ef && !done, "R12", "flags held after done", int'(cur_flags()), int'(ef));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] a;
        int         l;
        void'($urandom(32'd2024));
        rst = 1'b1; cmd_valid = 1'b0; cmd_slave = '0; cmd_payload = '0; cmd_ret = '0;
        ack_limit = 16'd50; gen_lat = 0; ack_lat = 0; ack_hang = 1'b0; wn = 0; rp = 0;
        repeat (3) @(negedge clk);
        chk({busy, done, bm_req} == 3'b000 && cur_flags() == 5'b0, "R13", "outputs in reset",
            int'({busy, done, bm_req}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, bm_req} == 3'b000 && cur_flags() == 5'b0, "R13", "outputs after reset",
            int'({busy, done, bm_req}), 0);

        // directed cases
        run_xfer(7'h21, 40'h0504030201, 8'h10, 8'h00, 0,   0, 0, 0, 16'd50, 0); // R4
        run_xfer(7'h3C, 40'hA1B2C3D4E5, 8'h42, 8'h01, 3,   0, 0, 1, 16'd50, 0); // R5 R6
        run_xfer(7'h05, 40'h1122334455, 8'h07, 8'h01, 0,   0, 0, 0, 16'd50, 0); // R5 empty reply
        run_xfer(7'h7F, 40'hFFFFFFFFFF, 8'hFF, 8'h00, 0,   0, 0, 0, 16'd50, 0); // R2 wraparound
        run_xfer(7'h12, 40'h0102030405, 8'h33, 8'h01, 125, 0, 0, 0, 16'd50, 0); // R8 largest length
        run_xfer(7'h12, 40'h0102030405, 8'h33, 8'h01, 126, 0, 0, 0, 16'd50, 0); // R8 first bad length
        run_xfer(7'h13, 40'h99AA55CC00, 8'h01, 8'h01, 200, 0, 0, 0, 16'd50, 0); // R8
        run_xfer(7'h44, 40'h0011223344, 8'h90, 8'h01, 9,   1, 0, 0, 16'd50, 0); // R7
        run_xfer(7'h45, 40'h0000000000, 8'h00, 8'h02, 0,   0, 0, 0, 16'd50, 0); // R9
        run_xfer(7'h46, 40'h8080808080, 8'h80, 8'hFF, 0,   0, 0, 0, 16'd50, 0); // R9
        run_xfer(7'h50, 40'h1234567890, 8'h11, 8'h01, 4,   0, 0, 6, 16'd6,  0); // R10 same cycle
        run_xfer(7'h51, 40'h1234567890, 8'h11, 8'h01, 4,   0, 0, 7, 16'd6,  0); // R10 one late
        run_xfer(7'h52, 40'hDEADBEEF01, 8'h22, 8'h00, 0,   0, 1, 0, 16'd10, 0); // R10 hung
        run_xfer(7'h53, 40'hCAFEF00D02, 8'h23, 8'h00, 0,   0, 0, 0, 16'd0,  0); // R10 zero limit
        gen_lat = 2;
        run_xfer(7'h60, 40'h0F1E2D3C4B, 8'h5A, 8'h01, 5,   0, 0, 2, 16'd20, 1); // R11 stray load

        // random mix
        for (int n = 0; n < 40; n++) begin
            gen_lat = int'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: a = 8'h00;
                1, 2, 3: a = 8'h01;
                default: a = 8'($urandom_range(2, 255));
            endcase
            l = ($urandom_range(0, 9) == 0) ? int'($urandom_range(126, 255)) : int'($urandom_range(0, 40));
            run_xfer(7'($urandom()), 40'({$urandom(), $urandom()}), 8'($urandom()), a, l,
                     ($urandom_range(0, 3) == 0), 1'b0, int'($urandom_range(0, 8)), 16'd8,
                     ($urandom_range(0, 5) == 0));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule